// File: doc/BRIEF.md
# Four-Bank SDRAM Burst Sequencer

This block models the data side of a four-bank synchronous DRAM. On each rising clock edge it takes one decoded command: load mode, open a row, column read, column write, burst stop or close bank. From a column command it generates the column address for every beat of the burst. It stores write data in a small on-chip array and returns read data after the programmed read latency. Refresh, power states and row timing other than read latency are not modelled.

The bank is chosen by the two top bits of `addr`. A controller opens a row in a bank, then issues reads and writes against that open row. A burst runs at one beat per clock. It ends after the programmed length, or earlier when the controller issues another column command, a burst stop, or a close of the bank. Two mask pins control the low and high data bytes separately. On writes they act in the same cycle. On reads they act two cycles later.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset every bank is closed, `dq_oe` is 0, and the mode is burst length 1, sequential order, read latency 2.
- R2: A mode load (`cmd`=1) takes its length code from `addr[2:0]` (0→1, 1→2, 2→4, 3→8, 7→full page), its order from `addr[3]` (0 sequential, 1 interleaved) and its latency from `addr[6:4]` (2 or 3). If any of these fields holds another value, the whole load is ignored.
- R3: Open (`cmd`=2) marks bank `addr[9:8]` open with row `addr[0]`. A read (`cmd`=3) or write (`cmd`=4) aimed at a closed bank is ignored.
- R4: A write stores beat 0 from `dq_in` in the cycle of the command and stores beat k k cycles later.
- R5: For a read issued in cycle 0, beat k is on `dq_out` with `dq_oe`=11 in cycle CL+k, where CL is the programmed latency.
- R6: In sequential order, beat k addresses column (start+k) mod BL inside the BL-aligned block that holds the start column.
- R7: In interleaved order, beat k addresses the start column with its low log2(BL) bits XORed with k.
- R8: A full-page burst steps through the columns, wraps from 255 to 0, and keeps going until it is stopped.
- R9: A column command issued during a burst ends that burst at once and starts a new one.
- R10: Burst stop (`cmd`=5) ends the burst. No beat is taken in the stop cycle or later, and read beats already issued still appear.
- R11: Close (`cmd`=6) closes bank `addr[9:8]`, or every bank when `ap`=1. A burst in a bank that is closed this way ends in that cycle.
- R12: A read or write issued with `ap`=1 closes its bank right after the last beat of a burst that runs to its full length.
- R13: During a write beat, `dqm_lo`/`dqm_hi` at 1 leave the low/high byte of the addressed word unchanged.
- R14: A read mask on `dqm_lo`/`dqm_hi` in cycle n clears `dq_oe[0]`/`dq_oe[1]` in cycle n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command: 0 idle, 1 mode, 2 open, 3 read, 4 write, 5 stop, 6 close |
| addr | input | COL_W+2 | Bank in top two bits; column, row or mode fields in low bits |
| ap | input | 1 | Auto close on read/write; all banks on close |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 2 | Output enable per byte, bit 0 low byte |
| dqm_lo | input | 1 | Low byte mask |
| dqm_hi | input | 1 | High byte mask |

## Verification
A corrupted beat counter or start column makes a wrong word appear on `dq_out`, one latency after the bad beat. This shows up within a single burst, because every bench pattern is unique per column. A stale burst-active flag shows up as `dq_oe` staying high past the expected last beat, or as extra words written that a later read exposes. Wrong per-bank open state turns a read into silence, or a silent read into data, within CL cycles. A mask-delay error flips a byte enable on the very beat it should affect.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W = 8,
  parameter int ROW_W = 1,
  parameter int DW    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cmd,
  input  logic [COL_W+1:0]   addr,
  input  logic               ap,
  input  logic [DW-1:0]      dq_in,
  output logic [DW-1:0]      dq_out,
  output logic [1:0]         dq_oe,
  input  logic               dqm_lo,
  input  logic               dqm_hi
);
  localparam int AW = COL_W + 2;
  localparam int MW = ROW_W + COL_W + 2;
  localparam int HB = DW / 2;
  localparam logic [2:0] C_MRS = 3'd1, C_ACT = 3'd2, C_RD = 3'd3,
                         C_WR = 3'd4, C_BST = 3'd5, C_PRE = 3'd6;

  logic [2:0]       bl_code;
  logic             wrap, cl3;
  logic [3:0]       bank_on;
  logic [ROW_W-1:0] open_row [4];
  logic             act, is_rd, apf;
  logic [1:0]       b_bank;
  logic [ROW_W-1:0] b_row;
  logic [COL_W-1:0] b_start, cnt, lenmask;
  logic [DW-1:0]    mem [1<<MW];
  logic [DW-1:0]    s1, s2, s3;
  logic             v1, v2, v3;
  logic [1:0]       m1, m2;

  wire [1:0]       cbank   = addr[AW-1:AW-2];
  wire [COL_W-1:0] ccol    = addr[COL_W-1:0];
  wire             col_cmd = (cmd == C_RD || cmd == C_WR) && bank_on[cbank];
  wire             full    = bl_code == 3'd7;

  always_comb
    case (bl_code)
      3'd0:    lenmask = '0;
      3'd1:    lenmask = COL_W'(1);
      3'd2:    lenmask = COL_W'(3);
      3'd3:    lenmask = COL_W'(7);
      default: lenmask = '1;
    endcase

  wire stop    = cmd == C_BST || (cmd == C_PRE && (ap || cbank == b_bank));
  wire cont    = act && !col_cmd && !stop;
  wire beat_wr = col_cmd ? (cmd == C_WR) : (cont && !is_rd);
  wire beat_rd = col_cmd ? (cmd == C_RD) : (cont && is_rd);
  wire last    = cont && !full && cnt == lenmask;
  wire first_last = col_cmd && !full && lenmask == '0;

  wire [COL_W-1:0] off = wrap ? (b_start ^ cnt) : (b_start + cnt);
  wire [COL_W-1:0] col = col_cmd ? ccol : ((b_start & ~lenmask) | (off & lenmask));
  wire [1:0]       bk  = col_cmd ? cbank : b_bank;
  wire [ROW_W-1:0] rw  = col_cmd ? open_row[cbank] : b_row;
  wire [MW-1:0]    idx = {bk, rw, col};

  wire bl_ok = addr[2:0] <= 3'd3 || addr[2:0] == 3'd7;
  wire cl_ok = addr[6:4] == 3'd2 || addr[6:4] == 3'd3;

  always_ff @(posedge clk)
    if (!rst_n) begin
      bl_code <= '0;
      wrap    <= 1'b0;
      cl3     <= 1'b0;
    end else if (cmd == C_MRS && bl_ok && cl_ok) begin
      bl_code <= addr[2:0];
      wrap    <= addr[3];
      cl3     <= addr[4];
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      bank_on <= '0;
      for (int i = 0; i < 4; i++) open_row[i] <= '0;
    end else begin
      if (last && apf) bank_on[b_bank] <= 1'b0;
      if (first_last && ap) bank_on[cbank] <= 1'b0;
      if (cmd == C_PRE) begin
        if (ap) bank_on <= '0;
        else    bank_on[cbank] <= 1'b0;
      end
      if (cmd == C_ACT) begin
        bank_on[cbank]  <= 1'b1;
        open_row[cbank] <= addr[ROW_W-1:0];
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      act     <= 1'b0;
      is_rd   <= 1'b0;
      apf     <= 1'b0;
      b_bank  <= '0;
      b_row   <= '0;
      b_start <= '0;
      cnt     <= '0;
    end else if (col_cmd) begin
      act     <= full || lenmask != '0;
      is_rd   <= cmd == C_RD;
      apf     <= ap;
      b_bank  <= cbank;
      b_row   <= open_row[cbank];
      b_start <= ccol;
      cnt     <= COL_W'(1);
    end else if (stop || last) begin
      act <= 1'b0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk) begin
    if (beat_wr) begin
      if (!dqm_lo) mem[idx][HB-1:0]  <= dq_in[HB-1:0];
      if (!dqm_hi) mem[idx][DW-1:HB] <= dq_in[DW-1:HB];
    end
    if (beat_rd) s1 <= mem[idx];
    s2 <= s1;
    s3 <= s2;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      {v1, v2, v3} <= '0;
      m1 <= '0;
      m2 <= '0;
    end else begin
      v1 <= beat_rd;
      v2 <= v1;
      v3 <= v2;
      m1 <= {dqm_hi, dqm_lo};
      m2 <= m1;
    end

  wire vout = cl3 ? v3 : v2;
  assign dq_out = cl3 ? s3 : s2;
  assign dq_oe  = vout ? ~m2 : 2'b00;

  // R6
  burst_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && !full |-> cnt <= lenmask);
  // R10
  bst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_BST |=> !act);
  // R12
  ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && apf && cmd != C_ACT |=> !bank_on[$past(b_bank)]);
  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_ACT |=> bank_on[$past(cbank)] && open_row[$past(cbank)] == $past(addr[ROW_W-1:0]));
  // R14
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm_hi, 2) |-> !dq_oe[1]);
endmodule

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;
  localparam int NS = 300;
  localparam logic [2:0] NOP = 0, MRS = 1, ACT = 2, RD = 3, WR = 4, BST = 5, PRE = 6;

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd = 0;
  logic [9:0] addr = 0;
  logic ap = 0, dqm_lo = 0, dqm_hi = 0;
  logic [15:0] dq_in = 0, dq_out;
  logic [1:0] dq_oe;

  sdram_burst_seq uut (.clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .ap(ap),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .dqm_lo(dqm_lo), .dqm_hi(dqm_hi));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  logic [15:0] sh [2048];
  logic brow [4];
  int cur_bl = 0, cur_cl = 2;
  logic cur_wr = 0;

  logic [2:0] sc_c [NS];
  logic [9:0] sc_a [NS];
  logic sc_p [NS];
  logic [15:0] sc_d [NS];
  logic [1:0] sc_m [NS];
  logic ex_k [NS];
  logic [1:0] ex_o [NS];
  logic [15:0] ex_d [NS];

  function automatic int ix(int b, int c);
    return b * 512 + int'(brow[b]) * 256 + (c & 255);
  endfunction

  function automatic int blen();
    return cur_bl == 7 ? 256 : (1 << cur_bl);
  endfunction

  function automatic int bcol(int s, int k);
    int m, o;
    m = blen() - 1;
    o = cur_wr ? (s ^ k) : (s + k);
    return (s & ~m & 255) | (o & m);
  endfunction

  task automatic clr();
    for (int i = 0; i < NS; i++) begin
      sc_c[i] = NOP; sc_a[i] = 0; sc_p[i] = 0; sc_d[i] = 0; sc_m[i] = 0;
      ex_k[i] = 0; ex_o[i] = 0; ex_d[i] = 0;
    end
  endtask

  task automatic sc(int i, logic [2:0] c, int b, int col, logic p, logic [15:0] d, logic [1:0] m);
    sc_c[i] = c; sc_a[i] = {b[1:0], col[7:0]}; sc_p[i] = p; sc_d[i] = d; sc_m[i] = m;
  endtask

  task automatic ex(int i, logic [1:0] o, logic [15:0] d);
    ex_k[i] = 1; ex_o[i] = o; ex_d[i] = d;
  endtask

  task automatic run(int n, string tag);
    logic [15:0] msk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ex_k[i]) begin
        tests++;
        msk = {{8{ex_o[i][1]}}, {8{ex_o[i][0]}}};
        if (dq_oe !== ex_o[i] || (dq_out & msk) !== (ex_d[i] & msk)) begin
          fails++;
          $display("FAIL %s slot %0d: oe %b data %h, expected oe %b data %h",
                   tag, i, dq_oe, dq_out & msk, ex_o[i], ex_d[i] & msk);
        end
      end
      cmd = sc_c[i]; addr = sc_a[i]; ap = sc_p[i]; dq_in = sc_d[i];
      {dqm_hi, dqm_lo} = sc_m[i];
    end
  endtask

  task automatic one(logic [2:0] c, int b, int col, logic p);
    clr(); sc(0, c, b, col, p, 0, 0); run(2, "setup");
  endtask

  task automatic mrs(int bl, logic w, int cl);
    one(MRS, 0, (cl << 4) | (int'(w) << 3) | bl, 0);
    if ((bl <= 3 || bl == 7) && (cl == 2 || cl == 3)) begin
      cur_bl = bl; cur_wr = w; cur_cl = cl;
    end
  endtask

  task automatic opn(int b, logic r);
    one(ACT, b, int'(r), 0); brow[b] = r;
  endtask

  task automatic wr_burst(int b, int col, logic [15:0] seed);
    clr();
    for (int k = 0; k < blen(); k++) begin
      sc(k, k == 0 ? WR : NOP, b, col, 0, seed + 16'(k), 0);
      sh[ix(b, bcol(col, k))] = seed + 16'(k);
    end
    run(blen() + 1, "write");
  endtask

  task automatic rd_burst(int b, int col, string tag);
    clr();
    sc(0, RD, b, col, 0, 0, 0);
    for (int k = 0; k < blen(); k++) ex(cur_cl + k, 2'b11, sh[ix(b, bcol(col, k))]);
    ex(cur_cl + blen(), 2'b00, 0);
    run(cur_cl + blen() + 1, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    tests++;
    if (dq_oe !== 2'b00) begin fails++; $display("FAIL R1 reset: oe %b expected 00", dq_oe); end
    clr(); sc(0, RD, 0, 0, 0, 0, 0); ex(2, 0, 0); ex(3, 0, 0); run(4, "R3 closed bank");
    opn(0, 0);
    clr(); sc(0, WR, 0, 5, 0, 16'h1357, 0); sc(1, NOP, 0, 0, 0, 16'hFFFF, 0); run(3, "write");
    sh[ix(0, 5)] = 16'h1357;
    clr(); sc(0, RD, 0, 5, 0, 0, 0); ex(2, 2'b11, 16'h1357); ex(3, 0, 0); run(4, "R1 default mode");
  endtask

  task automatic t_fullpage();
    mrs(7, 0, 2);
    opn(2, 1);
    for (int b = 0; b < 4; b += 2) begin
      clr();
      for (int k = 0; k < 256; k++) begin
        sc(k, k == 0 ? WR : NOP, b, 0, 0, {6'h2B, b[1:0], k[7:0]}, 0);
        sh[ix(b, k)] = {6'h2B, b[1:0], k[7:0]};
      end
      sc(256, BST, 0, 0, 0, 0, 0);
      run(258, "prefill");
    end
    clr(); sc(0, RD, 0, 250, 0, 0, 0); sc(12, BST, 0, 0, 0, 0, 0);
    for (int k = 0; k < 12; k++) ex(2 + k, 2'b11, sh[ix(0, 250 + k)]);
    ex(14, 0, 0); ex(15, 0, 0);
    run(16, "R8 R10 full page wrap");
    clr(); sc(0, WR, 0, 30, 0, 16'hC000, 0); sc(1, NOP, 0, 0, 0, 16'hC001, 0);
    sc(2, BST, 0, 0, 0, 16'hC002, 0); sc(3, NOP, 0, 0, 0, 16'hC003, 0);
    run(5, "write");
    sh[ix(0, 30)] = 16'hC000; sh[ix(0, 31)] = 16'hC001;
    clr(); sc(0, RD, 0, 30, 0, 0, 0); sc(3, BST, 0, 0, 0, 0, 0);
    ex(2, 2'b11, sh[ix(0, 30)]); ex(3, 2'b11, sh[ix(0, 31)]); ex(4, 2'b11, sh[ix(0, 32)]);
    ex(5, 0, 0);
    run(6, "R10 stop on write");
  endtask

  task automatic t_seq();
    mrs(2, 0, 2);
    wr_burst(0, 6, 16'h6000);
    rd_burst(0, 6, "R4 R6 BL4");
    mrs(3, 0, 2);
    rd_burst(0, 13, "R6 BL8");
    mrs(1, 0, 2);
    rd_burst(2, 9, "R6 BL2");
  endtask

  task automatic t_intl();
    mrs(3, 1, 3);
    rd_burst(2, 8'h13, "R5 R7 BL8 CL3");
    mrs(2, 1, 3);
    wr_burst(2, 8'h22, 16'h7000);
    rd_burst(2, 8'h22, "R7 R5 BL4 CL3");
    mrs(4, 0, 2);
    mrs(2, 0, 5);
    rd_burst(2, 8'h22, "R2 reserved load");
  endtask

  task automatic t_interrupt();
    mrs(2, 0, 2);
    clr(); sc(0, RD, 0, 40, 0, 0, 0); sc(2, RD, 0, 48, 0, 0, 0);
    ex(2, 2'b11, sh[ix(0, 40)]); ex(3, 2'b11, sh[ix(0, 41)]);
    for (int k = 0; k < 4; k++) ex(4 + k, 2'b11, sh[ix(0, 48 + k)]);
    ex(8, 0, 0);
    run(9, "R9 read cut");
    clr(); sc(0, WR, 0, 60, 0, 16'hE000, 0); sc(1, NOP, 0, 0, 0, 16'hE001, 0);
    sc(2, WR, 0, 70, 0, 16'hE100, 0);
    for (int k = 1; k < 4; k++) sc(2 + k, NOP, 0, 0, 0, 16'hE100 + 16'(k), 0);
    run(7, "write");
    sh[ix(0, 60)] = 16'hE000; sh[ix(0, 61)] = 16'hE001;
    sh[ix(0, 70)] = 16'hE100; sh[ix(0, 71)] = 16'hE101;
    sh[ix(0, 68)] = 16'hE102; sh[ix(0, 69)] = 16'hE103;
    rd_burst(0, 60, "R9 write cut");
    rd_burst(0, 68, "R9 write new");
  endtask

  task automatic t_pre();
    mrs(3, 0, 2);
    clr(); sc(0, RD, 2, 0, 0, 0, 0); sc(3, PRE, 2, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) ex(2 + k, 2'b11, sh[ix(2, k)]);
    ex(5, 0, 0);
    run(6, "R11 close cuts burst");
    clr(); sc(0, RD, 2, 0, 0, 0, 0); ex(2, 0, 0); ex(3, 0, 0); run(4, "R11 bank closed");
    opn(2, 1);
    one(PRE, 0, 0, 1);
    clr(); sc(0, RD, 0, 0, 0, 0, 0); sc(1, RD, 2, 0, 0, 0, 0);
    ex(2, 0, 0); ex(3, 0, 0); ex(4, 0, 0);
    run(5, "R11 close all");
    opn(0, 0); opn(2, 1);
  endtask

  task automatic t_ap();
    mrs(2, 0, 2);
    clr(); sc(0, RD, 0, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ex(2 + k, 2'b11, sh[ix(0, k)]);
    ex(6, 0, 0);
    sc(7, RD, 0, 0, 0, 0, 0); ex(9, 0, 0); ex(10, 0, 0);
    run(11, "R12 auto close");
    opn(0, 0);
  endtask

  task automatic t_mask();
    mrs(1, 0, 2);
    clr(); sc(0, WR, 0, 100, 0, 16'hAAAA, 2'b01); sc(1, NOP, 0, 0, 0, 16'hBBBB, 2'b10);
    run(3, "write");
    sh[ix(0, 100)] = {8'hAA, sh[ix(0, 100)][7:0]};
    sh[ix(0, 101)] = {sh[ix(0, 101)][15:8], 8'hBB};
    clr(); sc(0, RD, 0, 100, 0, 0, 0); sc(1, NOP, 0, 0, 0, 0, 2'b10);
    ex(2, 2'b11, sh[ix(0, 100)]); ex(3, 2'b01, sh[ix(0, 101)]); ex(4, 0, 0);
    run(5, "R13 R14 hi mask");
    clr(); sc(0, RD, 0, 100, 0, 0, 2'b01);
    ex(2, 2'b10, sh[ix(0, 100)]); ex(3, 2'b11, sh[ix(0, 101)]); ex(4, 0, 0);
    run(5, "R13 R14 lo mask");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) brow[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fullpage();
    t_seq();
    t_intl();
    t_interrupt();
    t_pre();
    t_ap();
    t_mask();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule